// File: doc/BRIEF.md
# Time Slot Interchange Switch Core

This block switches bytes between time slots of four serial streams that share one bit clock. Every frame carries 128 channels of 8 bits on each receive stream. The block shifts each received byte in and stores it in a data memory with two banks. It also steps through the same channel positions on four transmit streams. For every transmit slot, a connection word chosen by (stream, channel) decides what is sent. The choice is either a byte stored from any receive stream and channel, or a constant byte held in the connection word itself.

The connection word also sets four per-slot flags. The first picks processor (constant) mode. The second is a per-slot output enable. The third picks one-frame-buffered or same-frame delay. The fourth is a loopback flag, which stores the transmitted byte in place of the received one. Whether the outputs drive at all also depends on an output-disable pin and a standby bit in a control register. A processor loads the connection memory and the standby bit through simple write strobes. Tri-state is modelled by a separate enable output for each stream.

Top module: `tsi_switch_core`

## Requirements
- R1: With `ode_i` low and the standby bit 0, every `oe_o` bit is 0 for the whole frame.
- R2: With `ode_i` high, the standby bit has no effect: each `oe_o[s]` follows the per-slot enable flag even when standby is 0.
- R3: When `ode_i` is high or standby is 1, `oe_o[s]` during a slot equals that slot's enable flag (word bit 10): 1 drives, 0 is high impedance.
- R4: When the processor flag (word bit 9) is 1, word bits [7:0] are sent on that slot, MSB first.
- R5: When the processor flag is 0 and the delay flag (word bit 11) is 1, the slot sends the byte received in the previous frame on source stream word[8:7], channel word[6:0].
- R6: When the processor flag is 0 and the delay flag is 0, the slot reads the bank being filled in the current frame. A source channel lower than the output channel gives this frame's byte. A source channel that is equal or higher gives the byte from two frames back.
- R7: When the loopback flag (word bit 12) of slot (n,m) is 1, the byte stored for receive stream n channel m is the byte transmitted on stream n channel m, and `rx_i[n]` is ignored for that slot.
- R8: `fp_i` marks the clock of channel 0 bit 7. Slots follow one per 8 clocks. Each transmit bit appears on `tx_o` one clock after its slot bit time. The data-memory banks swap after the last bit of channel 127.
- R9: During reset, `tx_o` and `oe_o` are 0 and the standby bit clears to 0.
- R10: A cycle with `ctl_we` high loads `ctl_standby` into the standby bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high on channel 0 bit 7 |
| rx_i | input | 4 | Receive serial streams |
| ode_i | input | 1 | Global output-disable pin (high forces global enable) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_standby | input | 1 | Standby bit value to write |
| cm_we | input | 1 | Connection memory write strobe |
| cm_addr | input | 9 | Connection address: stream [8:7], channel [6:0] |
| cm_wdata | input | 13 | Connection word: loopback[12], delay[11], enable[10], processor[9], stream[8:7], channel[6:0] |
| tx_o | output | 4 | Transmit serial streams |
| oe_o | output | 4 | Per-stream drive enable for the current transmit bit |

## Verification
Receive bytes come from a formula in frame, stream and channel, so a byte from the wrong frame, wrong stream or wrong channel shows up as a mismatch. One source feeds a constant-delay slot, and two variable-delay slots use sources that lie before and after their output channels. Together these separate the previous-frame bank, the current-frame bank and the stale two-frame-old data. Constant bytes sit in channel 0, channel 5 and channel 127, which exposes any misalignment of the frame pulse or the one-clock transmit lag. A loopback slot feeds a buffered reader, which shows whether the transmitted byte or the receive pin was stored. The pin and standby combinations are each run for a whole frame to separate global from per-slot enable.

// File: rtl/tsi_pkg.sv
// Package: shared types for the time slot interchange core.
// Assumes the connection word keeps its four flags in its top four bits.
package tsi_pkg;

    // Flag group at the top of every connection word, MSB first.
    typedef struct packed {
        logic lpbk;   // store transmitted byte as the received byte
        logic vc;     // delay mode, see dly_mode_e
        logic oe;     // per-slot drive enable
        logic pc;     // processor mode: send constant from word
    } cm_flags_t;

    typedef enum logic {
        DLY_VARIABLE = 1'b0,
        DLY_CONSTANT = 1'b1
    } dly_mode_e;

    localparam int FLAG_W = 4;

endpackage

// File: rtl/tsi_frame_timer.sv
// Frame timer: tracks the bit position in the frame and the data-memory
// bank being filled. Assumes one frame is NCH*DW bit clocks; the frame
// pulse forces position 0 in the cycle it is high.
module tsi_frame_timer #(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_i,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] cnt_o,
    output logic             bank_o
);

    localparam logic [POS_W-1:0] LAST_POS = '1;

    logic [POS_W-1:0] cnt_q;
    logic             bank_q;

    // Current position: frame pulse realigns to slot 0.
    always_comb pos_o = fp_i ? '0 : cnt_q;

    // Advance position and swap bank after the last bit of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bank_q <= 1'b0;
        end else begin
            cnt_q <= pos_o + 1'b1;
            if (pos_o == LAST_POS)
                bank_q <= ~bank_q;
        end
    end

    assign cnt_o  = cnt_q;
    assign bank_o = bank_q;

endmodule

// File: rtl/tsi_rx_shifter.sv
// Receive deserializer: one shift register per stream, MSB first.
// rx_byte_o shows the byte completed by the current input bit, which is
// valid in the cycle of a channel's last bit.
module tsi_rx_shifter #(
    parameter int NS = 4,
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NS-1:0]  rx_i,
    output logic [NS*DW-1:0] rx_byte_o
);

    for (genvar s = 0; s < NS; s++) begin : g_st
        logic [DW-2:0] sh_q;

        // Shift in one bit per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[DW-3:0], rx_i[s]};
        end

        // Byte completed by the bit arriving now.
        always_comb rx_byte_o[s*DW +: DW] = {sh_q, rx_i[s]};
    end

endmodule

// File: rtl/tsi_data_mem.sv
// Data memory: two banks of NS x NCH bytes. All streams write the same
// channel in the same cycle into the bank being filled; each stream has
// its own asynchronous read port with its own bank, stream and channel.
// Contents are not reset.
module tsi_data_mem #(
    parameter int NS  = 4,
    parameter int NCH = 128,
    parameter int DW  = 8,
    parameter int SW  = 2,
    parameter int CHW = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wr_bank,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [NS*DW-1:0]  wdata,
    input  logic [NS-1:0]     rd_bank,
    input  logic [NS*SW-1:0]  rd_st,
    input  logic [NS*CHW-1:0] rd_ch,
    output logic [NS*DW-1:0]  rdata
);

    logic [DW-1:0] mem [2][NS][NCH];

    // Store every stream's completed byte at the end of its channel.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int s = 0; s < NS; s++)
                mem[wr_bank][s][wr_ch] <= wdata[s*DW +: DW];
        end
    end

    // One read port per transmit stream.
    for (genvar s = 0; s < NS; s++) begin : g_rd
        always_comb rdata[s*DW +: DW] =
            mem[rd_bank[s]][rd_st[s*SW +: SW]][rd_ch[s*CHW +: CHW]];
    end

endmodule

// File: rtl/tsi_conn_mem.sv
// Connection memory: one word per (stream, channel). Processor writes one
// word per cycle; the current channel is read for every stream at once.
// Contents are not reset and must be loaded before outputs are enabled.
module tsi_conn_mem #(
    parameter int NS  = 4,
    parameter int NCH = 128,
    parameter int SW  = 2,
    parameter int CHW = 7,
    parameter int CW  = 13
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SW+CHW-1:0] waddr,
    input  logic [CW-1:0]     wdata,
    input  logic [CHW-1:0]    rd_ch,
    output logic [NS*CW-1:0]  rdata
);

    logic [CW-1:0] cmem [NS][NCH];

    // Processor write port.
    always_ff @(posedge clk) begin
        if (we) cmem[waddr[SW+CHW-1:CHW]][waddr[CHW-1:0]] <= wdata;
    end

    // Per-stream read of the current channel's word.
    for (genvar s = 0; s < NS; s++) begin : g_rd
        always_comb rdata[s*CW +: CW] = cmem[s][rd_ch];
    end

endmodule

// File: rtl/tsi_switch_core.sv
// Time slot interchange core: deserializes NS receive streams into a
// double-buffered data memory and, per transmit slot, sends either a
// stored byte or a constant byte chosen by the connection memory.
// Assumes DW and NCH are powers of two and CHW+SW >= DW. Transmit bits
// and enables are registered: each appears one clock after its slot.
module tsi_switch_core #(
    parameter int NS  = 4,
    parameter int NCH = 128,
    parameter int DW  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fp_i,
    input  logic [NS-1:0]          rx_i,
    input  logic                   ode_i,
    input  logic                   ctl_we,
    input  logic                   ctl_standby,
    input  logic                   cm_we,
    input  logic [$clog2(NS)+$clog2(NCH)-1:0] cm_addr,
    input  logic [$clog2(NS)+$clog2(NCH)+tsi_pkg::FLAG_W-1:0] cm_wdata,
    output logic [NS-1:0]          tx_o,
    output logic [NS-1:0]          oe_o
);
    import tsi_pkg::*;

    localparam int SW    = $clog2(NS);
    localparam int CHW   = $clog2(NCH);
    localparam int BW    = $clog2(DW);
    localparam int POS_W = CHW + BW;
    localparam int CW    = SW + CHW + FLAG_W;
    localparam logic [BW-1:0] TOP_BIT = BW'(DW - 1);

    logic [POS_W-1:0]  cur_pos;
    logic [POS_W-1:0]  cnt_q;
    logic              wr_bank;
    logic [BW-1:0]     bit_idx;
    logic [BW-1:0]     msb_sel;
    logic [CHW-1:0]    cur_ch;
    logic              byte_end;
    logic              standby_q;
    logic              glob_en;
    logic [NS*DW-1:0]  rx_byte;
    logic [NS*DW-1:0]  dm_wdata;
    logic [NS*DW-1:0]  dm_rdata;
    logic [NS-1:0]     dm_rd_bank;
    logic [NS*SW-1:0]  dm_rd_st;
    logic [NS*CHW-1:0] dm_rd_ch;
    logic [NS*CW-1:0]  cm_rdata;
    logic [NS-1:0]     ch_oe;
    logic [NS-1:0]     ch_pc;
    logic [NS-1:0]     ch_pbit;
    logic [NS-1:0]     tx_bit;
    logic [NS-1:0]     tx_q;
    logic [NS-1:0]     oe_q;

    tsi_frame_timer #(.POS_W(POS_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .fp_i   (fp_i),
        .pos_o  (cur_pos),
        .cnt_o  (cnt_q),
        .bank_o (wr_bank)
    );

    // Split the frame position into channel and bit-in-channel.
    always_comb begin
        bit_idx  = cur_pos[BW-1:0];
        cur_ch   = cur_pos[POS_W-1:BW];
        msb_sel  = TOP_BIT - bit_idx;
        byte_end = (bit_idx == TOP_BIT);
        glob_en  = ode_i | standby_q;
    end

    tsi_rx_shifter #(.NS(NS), .DW(DW)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_i      (rx_i),
        .rx_byte_o (rx_byte)
    );

    tsi_conn_mem #(.NS(NS), .NCH(NCH), .SW(SW), .CHW(CHW), .CW(CW)) i_cm (
        .clk   (clk),
        .we    (cm_we),
        .waddr (cm_addr),
        .wdata (cm_wdata),
        .rd_ch (cur_ch),
        .rdata (cm_rdata)
    );

    tsi_data_mem #(.NS(NS), .NCH(NCH), .DW(DW), .SW(SW), .CHW(CHW)) i_dm (
        .clk     (clk),
        .we      (byte_end),
        .wr_bank (wr_bank),
        .wr_ch   (cur_ch),
        .wdata   (dm_wdata),
        .rd_bank (dm_rd_bank),
        .rd_st   (dm_rd_st),
        .rd_ch   (dm_rd_ch),
        .rdata   (dm_rdata)
    );

    // Per-stream slot decode: source select, constant mode, loopback.
    for (genvar s = 0; s < NS; s++) begin : g_slot
        logic [CW-1:0] word;
        cm_flags_t     flags;
        logic [DW-1:0] tx_byte;

        // Decode the connection word and pick the transmitted byte.
        always_comb begin
            word    = cm_rdata[s*CW +: CW];
            flags   = cm_flags_t'(word[CW-1 -: FLAG_W]);
            dm_rd_st[s*SW +: SW]    = word[CHW +: SW];
            dm_rd_ch[s*CHW +: CHW]  = word[CHW-1:0];
            dm_rd_bank[s] = (flags.vc == DLY_CONSTANT) ? ~wr_bank : wr_bank;
            tx_byte = flags.pc ? word[DW-1:0] : dm_rdata[s*DW +: DW];
            dm_wdata[s*DW +: DW] = flags.lpbk ? tx_byte : rx_byte[s*DW +: DW];
            tx_bit[s]  = tx_byte[msb_sel];
            ch_oe[s]   = flags.oe;
            ch_pc[s]   = flags.pc;
            ch_pbit[s] = word[msb_sel];
        end
    end

    // Control register: standby bit written by the processor.
    always_ff @(posedge clk) begin
        if (!rst_n)      standby_q <= 1'b0;
        else if (ctl_we) standby_q <= ctl_standby;
    end

    // Output register: one transmit bit and its drive enable per stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            oe_q <= '0;
        end else begin
            tx_q <= tx_bit;
            oe_q <= ch_oe & {NS{glob_en}};
        end
    end

    assign tx_o = tx_q;
    assign oe_o = oe_q;

endmodule

// File: rtl/tsi_switch_core_chk.sv
// Checker for tsi_switch_core: enable gating, constant-mode bits, frame
// alignment and control register updates. Bound into every instance.
module tsi_switch_core_chk #(
    parameter int NS    = 4,
    parameter int POS_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fp_i,
    input logic             ode_i,
    input logic             ctl_we,
    input logic             ctl_standby,
    input logic             standby_q,
    input logic [POS_W-1:0] cur_pos,
    input logic [POS_W-1:0] cnt_q,
    input logic             wr_bank,
    input logic [NS-1:0]    ch_oe,
    input logic [NS-1:0]    ch_pc,
    input logic [NS-1:0]    ch_pbit,
    input logic [NS-1:0]    tx_o,
    input logic [NS-1:0]    oe_o
);

    localparam logic [POS_W-1:0] LAST_POS = '1;
    localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);

    a_r1_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ode_i && !standby_q) |=> (oe_o == '0));

    a_r2_pin_overrides: assert property (@(posedge clk) disable iff (!rst_n)
        ode_i |=> (oe_o == $past(ch_oe)));

    for (genvar s = 0; s < NS; s++) begin : g_st
        a_r3_slot_off: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_oe[s] |=> !oe_o[s]);

        a_r4_const_bit: assert property (@(posedge clk) disable iff (!rst_n)
            ch_pc[s] |=> (tx_o[s] == $past(ch_pbit[s])));
    end

    a_r8_frame_align: assert property (@(posedge clk) disable iff (!rst_n)
        fp_i |=> (cnt_q == ONE_POS));

    a_r8_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_pos == LAST_POS) |=> (wr_bank != $past(wr_bank)));

    a_r10_standby_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (standby_q == $past(ctl_standby)));

endmodule

bind tsi_switch_core tsi_switch_core_chk #(.NS(NS), .POS_W(POS_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fp_i        (fp_i),
    .ode_i       (ode_i),
    .ctl_we      (ctl_we),
    .ctl_standby (ctl_standby),
    .standby_q   (standby_q),
    .cur_pos     (cur_pos),
    .cnt_q       (cnt_q),
    .wr_bank     (wr_bank),
    .ch_oe       (ch_oe),
    .ch_pc       (ch_pc),
    .ch_pbit     (ch_pbit),
    .tx_o        (tx_o),
    .oe_o        (oe_o)
);

// File: tb/test_tsi_switch_core.sv
`timescale 1ns/1ps
// Directed bench: each task runs one scenario and checks its own results.
module test_tsi_switch_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fp_i = 1'b0;
    logic [3:0]  rx_i = '0;
    logic        ode_i = 1'b1;
    logic        ctl_we = 1'b0;
    logic        ctl_standby = 1'b0;
    logic        cm_we = 1'b0;
    logic [8:0]  cm_addr = '0;
    logic [12:0] cm_wdata = '0;
    logic [3:0]  tx_o;
    logic [3:0]  oe_o;

    int errors = 0;
    int checks = 0;
    logic [7:0] cap_tx [4][128];
    logic       cap_oe [4][128];

    always #5 clk = ~clk;

    tsi_switch_core i_tsi_switch_core (
        .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .rx_i(rx_i), .ode_i(ode_i),
        .ctl_we(ctl_we), .ctl_standby(ctl_standby), .cm_we(cm_we),
        .cm_addr(cm_addr), .cm_wdata(cm_wdata), .tx_o(tx_o), .oe_o(oe_o)
    );

    function automatic logic [7:0] rxv(int fr, int s, int ch);
        return 8'((fr * 37 + s * 71 + ch * 13 + 5) & 255);
    endfunction

    // Switched word: {lpbk, delay, enable, proc=0, stream, channel}.
    function automatic logic [12:0] sw_word(logic lp, logic vc, logic oe,
                                            int st, int ch);
        return {lp, vc, oe, 1'b0, 2'(st), 7'(ch)};
    endfunction

    // Constant word: {lpbk, 0, enable, proc=1, byte}.
    function automatic logic [12:0] pc_word(logic lp, logic oe, logic [7:0] d);
        return {lp, 1'b0, oe, 1'b1, 1'b0, d};
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_cm(int s, int ch, logic [12:0] w);
        @(negedge clk);
        cm_we = 1'b1; cm_addr = {2'(s), 7'(ch)}; cm_wdata = w;
    endtask

    task automatic wr_standby(logic v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_standby = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic capture(int pp);
        int ch = pp >> 3;
        int b  = pp & 7;
        for (int s = 0; s < 4; s++) begin
            cap_tx[s][ch][7 - b] = tx_o[s];
            if (b == 0) cap_oe[s][ch] = oe_o[s];
            else        cap_oe[s][ch] = cap_oe[s][ch] | oe_o[s];
        end
    endtask

    // One frame of receive data; output bits are sampled one clock late.
    task automatic run_frame(int fr);
        for (int p = 0; p < 1024; p++) begin
            @(negedge clk);
            if (p > 0) capture(p - 1);
            fp_i = (p == 0);
            for (int s = 0; s < 4; s++) begin
                logic [7:0] v = rxv(fr, s, p >> 3);
                rx_i[s] = v[7 - (p & 7)];
            end
        end
        @(negedge clk);
        capture(1023);
        fp_i = 1'b0;
    endtask

    task automatic test_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", tx_o, 0, "tx during reset");
        chk("R9", oe_o, 0, "oe during reset");
        rst_n = 1'b1;
    endtask

    task automatic configure;
        for (int s = 0; s < 4; s++)
            for (int ch = 0; ch < 128; ch++)
                wr_cm(s, ch, pc_word(1'b0, 1'b0, 8'h00));
        wr_cm(0, 0,   pc_word(1'b0, 1'b1, 8'h81));
        wr_cm(0, 5,   pc_word(1'b0, 1'b1, 8'hC3));
        wr_cm(3, 127, pc_word(1'b0, 1'b1, 8'h5A));
        wr_cm(1, 40,  sw_word(1'b0, 1'b1, 1'b1, 2, 17));
        wr_cm(2, 60,  sw_word(1'b0, 1'b0, 1'b1, 3, 12));
        wr_cm(3, 9,   sw_word(1'b0, 1'b0, 1'b1, 0, 100));
        wr_cm(0, 10,  pc_word(1'b1, 1'b1, 8'hA5));
        wr_cm(1, 20,  sw_word(1'b0, 1'b1, 1'b1, 0, 10));
        wr_cm(2, 70,  pc_word(1'b0, 1'b0, 8'h77));
        @(negedge clk);
        cm_we = 1'b0;
    endtask

    task automatic test_switching;
        ode_i = 1'b1;
        run_frame(0);
        run_frame(1);
        run_frame(2);
        chk("R8", cap_tx[0][0], 8'h81, "channel 0 constant byte alignment");
        chk("R8", cap_tx[3][127], 8'h5A, "channel 127 constant byte");
        chk("R4", cap_tx[0][5], 8'hC3, "constant byte on (0,5)");
        chk("R3", cap_oe[0][5], 1, "enable of driven slot");
        chk("R3", cap_oe[2][70], 0, "enable of disabled slot");
        chk("R2", cap_oe[0][0], 1, "pin high, standby 0 still drives");
        chk("R5", cap_tx[1][40], rxv(1, 2, 17), "buffered byte from (2,17)");
        chk("R6", cap_tx[2][60], rxv(2, 3, 12), "same-frame byte from (3,12)");
        chk("R6", cap_tx[3][9], rxv(0, 0, 100), "later source gives stale byte");
        chk("R7", cap_tx[1][20], 8'hA5, "looped-back byte stored for (0,10)");
    endtask

    task automatic test_global_off;
        int on = 0;
        ode_i = 1'b0;
        run_frame(3);
        for (int s = 0; s < 4; s++)
            for (int ch = 0; ch < 128; ch++)
                if (cap_oe[s][ch]) on++;
        chk("R1", on, 0, "slots driving with pin low and standby 0");
    endtask

    task automatic test_standby;
        wr_standby(1'b1);
        run_frame(4);
        chk("R10", cap_oe[0][5], 1, "standby 1 enables slot");
        chk("R3", cap_oe[2][70], 0, "slot flag still disables");
        chk("R5", cap_tx[1][40], rxv(3, 2, 17), "buffered byte, later frame");
    endtask

    task automatic test_pin_override;
        wr_standby(1'b0);
        ode_i = 1'b1;
        run_frame(5);
        chk("R2", cap_oe[3][127], 1, "pin overrides standby 0");
        chk("R6", cap_tx[2][60], rxv(5, 3, 12), "same-frame byte, later frame");
        chk("R7", cap_tx[1][20], 8'hA5, "receive pin ignored on loopback slot");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset();
        configure();
        test_switching();
        test_global_off();
        test_standby();
        test_pin_override();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule